// File: doc/BRIEF.md
# Loadable Incrementing Program Counter

This block holds the address of the next instruction as a 16-bit register. Three synchronous control inputs act at each rising clock edge: a clear forces the count to zero, a load copies a value from the data bus, and an increment advances the count by one. When more than one control is high, clear wins over load, and load wins over increment. With all three low, the register keeps its value.

The count output comes straight from the state register, so a control sampled at an edge shows on the output only after that edge. The register has no value at power-up. The surrounding logic must clear it once before it uses the count. Internally, each bit is a flip-flop fed by a two-way choice between its held value and a new value, and the choice acts as a per-bit clock enable. The new value is picked from zero, the bus, or the output of a ripple incrementer.

The interface has no valid/ready handshake. The count is a state value rather than a stream, and all pins are plain controls and data that are sampled at every edge, with no back-pressure.

Top module: `pc_counter`

## Requirements
- R1: The count is W bits wide (default 16), driven only by the state register; changing clr, ld, inc or din between clock edges leaves count unchanged until the next rising edge.
- R2: When clr is 1 at a rising edge, count becomes 0 in the next cycle, whatever ld, inc and din are.
- R3: When clr is 0 and ld is 1 at a rising edge, count becomes the value on din, whatever inc is.
- R4: When clr and ld are 0 and inc is 1 at a rising edge, count becomes the previous count plus one.
- R5: When clr, ld and inc are all 0 at a rising edge, count keeps its value.
- R6: Incrementing from all ones (16'hFFFF by default) gives all zeros, with no carry or error output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr | input | 1 | Synchronous clear to zero, highest priority |
| ld | input | 1 | Synchronous parallel load from din |
| inc | input | 1 | Synchronous increment by one, lowest priority |
| din | input | W | Value taken on a load |
| count | output | W | Current count, straight from the register |

## Verification
The bench goes after the cases where more than one control is high, driving clr together with ld and inc, and ld together with inc. A design with the priority order wrong would load when it should clear, or increment when it should load. It also loads all ones and then increments. A design whose incrementer dropped or misrouted the top carry would show a non-zero value there instead of wrapping to zero. Finally, it changes controls and din in the middle of a cycle and samples before the edge, which catches any combinational path from the inputs to count. Long random runs with mostly idle cycles also expose a hold case that drifts or clears when it should keep its value.

// File: rtl/pc_pkg.sv
`timescale 1ns/1ps
package pc_pkg;
  localparam int unsigned PC_W_DEF = 16;

  typedef enum logic [1:0] {
    SEL_HOLD = 2'd0,
    SEL_ZERO = 2'd1,
    SEL_BUS  = 2'd2,
    SEL_STEP = 2'd3
  } pc_sel_e;
endpackage

// File: rtl/pc_ctrl.sv
`timescale 1ns/1ps
module pc_ctrl
  import pc_pkg::*;
(
  input  logic    clr,
  input  logic    ld,
  input  logic    inc,
  output pc_sel_e sel
);
  always_comb begin
    if (clr)      sel = SEL_ZERO;
    else if (ld)  sel = SEL_BUS;
    else if (inc) sel = SEL_STEP;
    else          sel = SEL_HOLD;
  end
endmodule

// File: rtl/pc_incr.sv
`timescale 1ns/1ps
module pc_incr #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] a,
  output logic [W-1:0] y
);
  logic [W:0] carry;
  assign carry[0] = 1'b1;

  for (genvar b = 0; b < W; b++) begin : g_half
    assign y[b]       = a[b] ^ carry[b];
    assign carry[b+1] = a[b] & carry[b];
  end
endmodule

// File: rtl/pc_bit_cell.sv
`timescale 1ns/1ps
module pc_bit_cell (
  input  logic clk,
  input  logic en,
  input  logic nv,
  output logic q
);
  logic d;
  assign d = en ? nv : q;

  always_ff @(posedge clk) begin
    q <= d;
  end
endmodule

// File: rtl/pc_counter.sv
`timescale 1ns/1ps
module pc_counter
  import pc_pkg::*;
#(
  parameter int unsigned W = PC_W_DEF
) (
  input  logic         clk,
  input  logic         clr,
  input  logic         ld,
  input  logic         inc,
  input  logic [W-1:0] din,
  output logic [W-1:0] count
);
  pc_sel_e      sel;
  logic [W-1:0] stepped;
  logic [W-1:0] nv;
  logic [W-1:0] q;
  logic         en;

  pc_ctrl u_ctrl (
    .clr (clr),
    .ld  (ld),
    .inc (inc),
    .sel (sel)
  );

  pc_incr #(.W(W)) u_incr (
    .a (q),
    .y (stepped)
  );

  always_comb begin
    unique case (sel)
      SEL_ZERO: nv = '0;
      SEL_BUS:  nv = din;
      SEL_STEP: nv = stepped;
      default:  nv = q;
    endcase
  end

  assign en = (sel != SEL_HOLD);

  for (genvar b = 0; b < W; b++) begin : g_bit
    pc_bit_cell u_cell (
      .clk (clk),
      .en  (en),
      .nv  (nv[b]),
      .q   (q[b])
    );
  end

  assign count = q;
endmodule

// File: rtl/pc_counter_chk.sv
`timescale 1ns/1ps
module pc_counter_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk,
  input logic         clr,
  input logic         ld,
  input logic         inc,
  input logic [W-1:0] din,
  input logic [W-1:0] count
);
  typedef logic [W-1:0] word_t;

  logic armed_q = 1'b0;
  always_ff @(posedge clk) begin
    armed_q <= armed_q | clr;
  end

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!armed_q)
    clr |=> (count == '0)) else $error("clear did not zero count"); // R2

  AST_LOAD_BUS: assert property (@(posedge clk) disable iff (!armed_q)
    (!clr && ld) |=> (count == $past(din))) else $error("load mismatch"); // R3

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!armed_q)
    (!clr && !ld && inc) |=> (count == word_t'($past(count) + word_t'(1))))
    else $error("increment mismatch"); // R4

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!armed_q)
    (!clr && !ld && !inc) |=> $stable(count)) else $error("hold drifted"); // R5

  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!armed_q)
    (!clr && !ld && inc && (count == '1)) |=> (count == '0))
    else $error("wrap failed"); // R6
endmodule

bind pc_counter pc_counter_chk #(.W(W)) u_chk (
  .clk   (clk),
  .clr   (clr),
  .ld    (ld),
  .inc   (inc),
  .din   (din),
  .count (count)
);

// File: tb/pc_counter_tb_top.sv
`timescale 1ns/1ps
module pc_counter_tb_top;
  localparam int W = 16;

  typedef struct {
    logic [W-1:0] exp;
    string        req;
  } item_t;

  logic         clk = 1'b0;
  logic         clr = 1'b0;
  logic         ld  = 1'b0;
  logic         inc = 1'b0;
  logic [W-1:0] din = '0;
  logic [W-1:0] count;

  item_t        sb_q[$];
  logic [W-1:0] model = '0;
  int           n_chk = 0;
  int           n_fail = 0;
  bit           done = 1'b0;

  always #10 clk = ~clk;

  pc_counter #(.W(W)) dut_i (
    .clk   (clk),
    .clr   (clr),
    .ld    (ld),
    .inc   (inc),
    .din   (din),
    .count (count)
  );

  task automatic check(input logic [W-1:0] exp, input string req);
    n_chk++;
    if (count !== exp) begin
      n_fail++;
      $display("FAIL %s: count=%h expected=%h at %0t", req, count, exp, $time);
    end
  endtask

  task automatic drive(input logic c, input logic l, input logic i,
                       input logic [W-1:0] v);
    item_t it;
    string tag;
    @(negedge clk);
    clr = c; ld = l; inc = i; din = v;
    if (c)      begin tag = "R2"; model = '0; end
    else if (l) begin tag = "R3"; model = v; end
    else if (i) begin tag = (model == '1) ? "R6" : "R4"; model = model + 1'b1; end
    else        tag = "R5";
    it.exp = model;
    it.req = tag;
    sb_q.push_back(it);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // monitor: compare each scoreboard item half a phase after its edge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        check(it.exp, it.req);
      end
    end
  end

  initial begin
    #3000000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: count=%h expected=end of run", count);
    finish_run();
  end

  initial begin
    logic [W-1:0] snap;
    // reset state: clear with load and inc also high (R2)
    drive(1, 1, 1, 16'hBEEF);
    drive(0, 0, 0, 16'h0000);           // R5 hold at zero
    drive(0, 0, 1, 16'h1111);           // R4 step
    drive(0, 0, 1, 16'h2222);           // R4 step
    drive(0, 1, 1, 16'h1234);           // R3 load over inc
    drive(0, 1, 0, 16'h8000);           // R3 plain load
    drive(0, 0, 0, 16'h7777);           // R5 din ignored on hold
    drive(1, 0, 1, 16'h0000);           // R2 clear over inc
    drive(0, 1, 0, 16'hFFFE);           // R3
    drive(0, 0, 1, 16'h0000);           // R4 to FFFF
    drive(0, 0, 1, 16'h0000);           // R6 wrap
    drive(0, 0, 1, 16'h0000);           // R4 after wrap
    drive(0, 1, 1, 16'hFFFF);
    drive(0, 0, 1, 16'h0000);           // R6 wrap again
    drive(1, 1, 0, 16'hAAAA);           // R2 clear over load

    // R1: mid-cycle control changes must not reach count before the edge
    drive(0, 1, 0, 16'h0F0F);
    @(negedge clk);
    clr = 1'b0; ld = 1'b0; inc = 1'b0;
    wait (sb_q.size() == 0);
    #1;
    snap = count;
    ld = 1'b1; din = 16'h5A5A; inc = 1'b1;
    #3;
    check(snap, "R1");
    clr = 1'b1;
    #2;
    check(snap, "R1");
    clr = 1'b0; ld = 1'b0; inc = 1'b0;

    // random mix, mostly idle and stepping
    for (int k = 0; k < 400; k++) begin
      int r;
      r = $urandom_range(0, 99);
      drive(r < 5, (r >= 5) && (r < 20), ($urandom_range(0, 2) != 0) && (r >= 5),
            16'($urandom()));
    end
    drive(0, 1, 0, 16'hFFFF);
    drive(0, 0, 1, 16'h0000);           // R6 final wrap
    drive(0, 0, 0, 16'h0000);
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule